// File: doc/BRIEF.md
# Indexed-Colour Display Control Registers

This block is the register file that sits between a 32-bit word bus and the pixel pipeline of an 8-bit indexed-colour display controller. It stores a 256-entry colour lookup table of 24-bit RGB, a three-entry cursor colour table and a 512-word cursor bitmap. It also stores the cursor position, a control word, the screen start offset and the visible width and height. Video timing and frame memory live elsewhere.

Software writes through one address/write-enable/data port. Each write takes effect on the clock edge it is presented on. Read data is a combinational function of the address. The port has no back-pressure and no stall: every access completes in one cycle, so control and status pins are plain levels and strobes.

A second, index-driven read port on each table lets the pixel pipeline look up colours and bitmap words without contending with the bus. The block decodes the control word into a blank flag, a cursor-enable flag and a pixel depth. An interrupt line is raised by a frame-done strobe and dropped by any bus write. Width and height use scaled encodings: width is written in units of four pixels, and height is written in half-lines.

Top module: `fbctl_regfile`

## Requirements
- R1: A write in the byte range 0x800 to 0xFFF stores lookup entry (address bits 10:3), with red from data bits 23:16, green from 15:8 and blue from 7:0. `pix_rgb` presents entry `pix_index` as {red, green, blue}. A bus read of this range returns zero.
- R2: Writes at 0x508, 0x510 and 0x518 store cursor colours 0, 1 and 2 with the same RGB packing. A read at those addresses returns {8'h00, red, green, blue}. `curs_rgb` shows entry `curs_idx`, and index 3 gives zero.
- R3: A write in the byte range 0x1000 to 0x1FFF stores data bits 15:0 into bitmap word (address bits 11:3). A read returns that word zero-extended, and `pat_word` shows word `pat_index`.
- R4: A write at 0x118 sets `width_px` to the low DIM_W bits of data times 4. A read there returns `width_px` divided by 4.
- R5: A write at 0x150 sets `height_ln` to data divided by 2, truncated to DIM_W bits. A read returns `height_ln` times 2.
- R6: The control word at 0x300 reads back as written. `force_blank` follows bit 10, and `cursor_on` is the inverse of bit 23.
- R7: `depth_bits` decodes control bits 22:20 as follows: codes 0 to 7 give 1, 2, 4, 8, 15, 16, 0 and 0 bits per pixel.
- R8: A write at 0x638 sets `cursor_x` to data bits 31:12 and `cursor_y` to bits 11:0. A write at 0x400 sets `screen_base` to the data.
- R9: Writes to 0x000, 0x108 to 0x148 (except 0x118), 0x158 to 0x170 and 0x200 change no state. Reads of the timing addresses, of 0x400, of 0x638 and of any address outside R1 to R6 return zero.
- R10: A write at 0x100000 clears both colour tables, the bitmap, the cursor position, the control word, the screen offset, the width and the height, and it drops `irq`.
- R11: A `frame_done` pulse sets `irq` on the next edge. Any bus write clears it on the next edge, and clear wins when both occur in the same cycle. Otherwise `irq` holds.
- R12: After reset, all state is zero and `irq` is low. As a result, `cursor_on` is 1 and `depth_bits` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 21 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| frame_done | input | 1 | End-of-frame strobe that raises irq |
| irq | output | 1 | Interrupt level |
| pix_index | input | 8 | Lookup index from the pixel pipeline |
| pix_rgb | output | 24 | Colour of lookup entry pix_index |
| curs_idx | input | 2 | Cursor colour select |
| curs_rgb | output | 24 | Cursor colour for curs_idx |
| pat_index | input | 9 | Cursor bitmap word select |
| pat_word | output | 16 | Cursor bitmap word |
| force_blank | output | 1 | Display forced blank |
| cursor_on | output | 1 | Cursor enabled |
| depth_bits | output | 5 | Decoded pixel depth in bits |
| cursor_x | output | 20 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| screen_base | output | 32 | Screen start offset in frame memory |
| width_px | output | 16 | Visible width in pixels |
| height_ln | output | 16 | Visible height in lines |

## Verification
Every cycle, the assertions check the interrupt rules, including clear winning over set. They check the scaling of width and height writes and the cursor position split. They check that the soft reset leaves the scalar outputs at zero, that the control flags and depth agree with the control word read back, and that an unmapped read gives zero. The table contents depend on many earlier writes, so only the bench's scenarios can show them. These cover lookup and bitmap indexing, the RGB packing through both read ports, timing writes leaving all state alone, and the soft reset emptying the tables.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

  localparam int ADDR_W = 21;
  localparam int DATA_W = 32;

  // Address map; windows are [base, base + span)
  localparam logic [ADDR_W-1:0] A_CLUT   = 21'h000800;
  localparam logic [ADDR_W-1:0] A_CLUT_E = 21'h001000;
  localparam logic [ADDR_W-1:0] A_CPAL   = 21'h000508;
  localparam logic [ADDR_W-1:0] A_CPAL_E = 21'h000520;
  localparam logic [ADDR_W-1:0] A_CPAT   = 21'h001000;
  localparam logic [ADDR_W-1:0] A_CPAT_E = 21'h002000;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 21'h000118;
  localparam logic [ADDR_W-1:0] A_HEIGHT = 21'h000150;
  localparam logic [ADDR_W-1:0] A_CTRL   = 21'h000300;
  localparam logic [ADDR_W-1:0] A_BASE   = 21'h000400;
  localparam logic [ADDR_W-1:0] A_CPOS   = 21'h000638;
  localparam logic [ADDR_W-1:0] A_SRST   = 21'h100000;

  // Control word fields
  localparam int CTRL_BLANK_BIT  = 10;
  localparam int CTRL_NOCURS_BIT = 23;
  localparam int CTRL_DEPTH_LSB  = 20;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_TIMING, SEL_CLUT, SEL_CPAL, SEL_CPAT,
    SEL_WIDTH, SEL_HEIGHT, SEL_CTRL, SEL_CPOS, SEL_BASE, SEL_SRST
  } sel_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic is_timing(input logic [ADDR_W-1:0] a);
    case (a)
      21'h000, 21'h108, 21'h110, 21'h120, 21'h128, 21'h130, 21'h138,
      21'h140, 21'h148, 21'h158, 21'h160, 21'h168, 21'h170, 21'h200:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
  import fbctl_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);

  logic [ADDR_W-1:0] off_clut, off_cpal, off_cpat;

  assign off_clut = addr - A_CLUT;
  assign off_cpal = addr - A_CPAL;
  assign off_cpat = addr - A_CPAT;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addr >= A_CLUT && addr < A_CLUT_E) begin
      sel = SEL_CLUT;
      idx = IDX_W'(off_clut >> 3);
    end else if (addr >= A_CPAT && addr < A_CPAT_E) begin
      sel = SEL_CPAT;
      idx = IDX_W'(off_cpat >> 3);
    end else if (addr >= A_CPAL && addr < A_CPAL_E) begin
      sel = SEL_CPAL;
      idx = IDX_W'(off_cpal >> 3);
    end else begin
      case (addr)
        A_WIDTH:  sel = SEL_WIDTH;
        A_HEIGHT: sel = SEL_HEIGHT;
        A_CTRL:   sel = SEL_CTRL;
        A_CPOS:   sel = SEL_CPOS;
        A_BASE:   sel = SEL_BASE;
        A_SRST:   sel = SEL_SRST;
        default:  sel = is_timing(addr) ? SEL_TIMING : SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/fbctl_table.sv
module fbctl_table #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 24,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    a_idx,
  output logic [WIDTH-1:0] a_data,
  input  logic [IW-1:0]    b_idx,
  output logic [WIDTH-1:0] b_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (32'(widx) < DEPTH)) begin
      mem[widx] <= wdata;
    end
  end

  generate
    if (DEPTH == (1 << IW)) begin : g_full
      assign a_data = mem[a_idx];
      assign b_data = mem[b_idx];
    end else begin : g_partial
      assign a_data = (32'(a_idx) < DEPTH) ? mem[a_idx] : '0;
      assign b_data = (32'(b_idx) < DEPTH) ? mem[b_idx] : '0;
    end
  endgenerate

endmodule

// File: rtl/fbctl_ctrl.sv
module fbctl_ctrl
  import fbctl_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_done,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] cpos,
  output logic [DATA_W-1:0] base,
  output logic [DIM_W-1:0]  width_px,
  output logic [DIM_W-1:0]  height_ln,
  output logic              irq
);

  logic srst;
  assign srst = we && (sel == SEL_SRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= '0;
      cpos      <= '0;
      base      <= '0;
      width_px  <= '0;
      height_ln <= '0;
    end else if (srst) begin
      ctrl_word <= '0;
      cpos      <= '0;
      base      <= '0;
      width_px  <= '0;
      height_ln <= '0;
    end else if (we) begin
      case (sel)
        SEL_CTRL:   ctrl_word <= wdata;
        SEL_CPOS:   cpos      <= wdata;
        SEL_BASE:   base      <= wdata;
        SEL_WIDTH:  width_px  <= DIM_W'(wdata << 2);
        SEL_HEIGHT: height_ln <= DIM_W'(wdata >> 1);
        default: ;
      endcase
    end
  end

  // Any write clears; clear has priority over the frame strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq <= 1'b0;
    else if (we)         irq <= 1'b0;
    else if (frame_done) irq <= 1'b1;
  end

endmodule

// File: rtl/fbctl_regfile.sv
module fbctl_regfile
  import fbctl_pkg::*;
#(
  parameter int DIM_W      = 16,
  parameter int CLUT_DEPTH = 256,
  parameter int CPAL_DEPTH = 3,
  parameter int CPAT_DEPTH = 512,
  parameter int CPAT_W     = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [20:0]                         bus_addr,
  input  logic                                bus_we,
  input  logic [31:0]                         bus_wdata,
  output logic [31:0]                         bus_rdata,
  input  logic                                frame_done,
  output logic                                irq,
  input  logic [$clog2(CLUT_DEPTH)-1:0]       pix_index,
  output logic [23:0]                         pix_rgb,
  input  logic [1:0]                          curs_idx,
  output logic [23:0]                         curs_rgb,
  input  logic [$clog2(CPAT_DEPTH)-1:0]       pat_index,
  output logic [CPAT_W-1:0]                   pat_word,
  output logic                                force_blank,
  output logic                                cursor_on,
  output logic [4:0]                          depth_bits,
  output logic [19:0]                         cursor_x,
  output logic [11:0]                         cursor_y,
  output logic [31:0]                         screen_base,
  output logic [DIM_W-1:0]                    width_px,
  output logic [DIM_W-1:0]                    height_ln
);

  localparam int CLUT_IW = $clog2(CLUT_DEPTH);
  localparam int CPAL_IW = 2;
  localparam int CPAT_IW = $clog2(CPAT_DEPTH);
  localparam int DEC_IW  = (CPAT_IW > CLUT_IW) ? CPAT_IW : CLUT_IW;

  sel_e              sel;
  logic [DEC_IW-1:0] dec_idx;
  logic              srst;
  rgb_t              wr_rgb;
  logic [23:0]       clut_a, cpal_a;
  logic [CPAT_W-1:0] cpat_a;
  logic [31:0]       ctrl_word, cpos;

  fbctl_decode #(.IDX_W(DEC_IW)) u_dec (
    .addr(bus_addr), .sel(sel), .idx(dec_idx)
  );

  assign srst   = bus_we && (sel == SEL_SRST);
  assign wr_rgb = '{r: bus_wdata[23:16], g: bus_wdata[15:8], b: bus_wdata[7:0]};

  fbctl_table #(.DEPTH(CLUT_DEPTH), .WIDTH(24)) u_clut (
    .clk(clk), .rst_n(rst_n), .clr(srst),
    .we(bus_we && sel == SEL_CLUT), .widx(dec_idx[CLUT_IW-1:0]), .wdata(wr_rgb),
    .a_idx(dec_idx[CLUT_IW-1:0]), .a_data(clut_a),
    .b_idx(pix_index), .b_data(pix_rgb)
  );

  fbctl_table #(.DEPTH(CPAL_DEPTH), .WIDTH(24)) u_cpal (
    .clk(clk), .rst_n(rst_n), .clr(srst),
    .we(bus_we && sel == SEL_CPAL), .widx(dec_idx[CPAL_IW-1:0]), .wdata(wr_rgb),
    .a_idx(dec_idx[CPAL_IW-1:0]), .a_data(cpal_a),
    .b_idx(curs_idx), .b_data(curs_rgb)
  );

  fbctl_table #(.DEPTH(CPAT_DEPTH), .WIDTH(CPAT_W)) u_cpat (
    .clk(clk), .rst_n(rst_n), .clr(srst),
    .we(bus_we && sel == SEL_CPAT), .widx(dec_idx[CPAT_IW-1:0]),
    .wdata(bus_wdata[CPAT_W-1:0]),
    .a_idx(dec_idx[CPAT_IW-1:0]), .a_data(cpat_a),
    .b_idx(pat_index), .b_data(pat_word)
  );

  fbctl_ctrl #(.DIM_W(DIM_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .sel(sel), .wdata(bus_wdata),
    .frame_done(frame_done), .ctrl_word(ctrl_word), .cpos(cpos),
    .base(screen_base), .width_px(width_px), .height_ln(height_ln), .irq(irq)
  );

  assign force_blank = ctrl_word[CTRL_BLANK_BIT];
  assign cursor_on   = !ctrl_word[CTRL_NOCURS_BIT];
  assign depth_bits  = depth_of(ctrl_word[CTRL_DEPTH_LSB +: 3]);
  assign cursor_x    = cpos[31:12];
  assign cursor_y    = cpos[11:0];

  // Read mux; the colour lookup window is write-only
  always_comb begin
    case (sel)
      SEL_CPAL:   bus_rdata = {8'h00, cpal_a};
      SEL_CPAT:   bus_rdata = 32'(cpat_a);
      SEL_WIDTH:  bus_rdata = 32'(width_px >> 2);
      SEL_HEIGHT: bus_rdata = 32'({height_ln, 1'b0});
      SEL_CTRL:   bus_rdata = ctrl_word;
      default:    bus_rdata = '0;
    endcase
  end

  logic unused_clut;
  assign unused_clut = ^clut_a;

endmodule

// File: rtl/fbctl_regfile_chk.sv
module fbctl_regfile_chk #(
  parameter int DIM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [20:0]      bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             frame_done,
  input logic             irq,
  input logic             force_blank,
  input logic             cursor_on,
  input logic [4:0]       depth_bits,
  input logic [19:0]      cursor_x,
  input logic [11:0]      cursor_y,
  input logic [31:0]      screen_base,
  input logic [DIM_W-1:0] width_px,
  input logic [DIM_W-1:0] height_ln
);

  logic [4:0] exp_depth;
  always_comb begin
    unique case (bus_rdata[22:20])
      3'b000: exp_depth = 5'd1;
      3'b001: exp_depth = 5'd2;
      3'b010: exp_depth = 5'd4;
      3'b011: exp_depth = 5'd8;
      3'b100: exp_depth = 5'd15;
      3'b101: exp_depth = 5'd16;
      default: exp_depth = 5'd0;
    endcase
  end

  assert_write_clears_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !irq);
  assert_frame_sets_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !bus_we) |=> irq);
  assert_irq_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !bus_we) |=> $stable(irq));
  assert_width_scale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 21'h118) |=> width_px == DIM_W'($past(bus_wdata) << 2));
  assert_height_halve_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 21'h150) |=> height_ln == DIM_W'($past(bus_wdata) >> 1));
  assert_cursor_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 21'h638) |=>
      (cursor_x == $past(bus_wdata[31:12]) && cursor_y == $past(bus_wdata[11:0])));
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 21'h100000) |=>
      (width_px == '0 && height_ln == '0 && screen_base == '0 && cursor_x == '0 &&
       cursor_y == '0 && !force_blank && cursor_on && depth_bits == 5'd1 && !irq));
  assert_ctrl_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 21'h300) |-> (force_blank == bus_rdata[10] && cursor_on == !bus_rdata[23]));
  assert_depth_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 21'h300) |-> depth_bits == exp_depth);
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 21'h004 || bus_addr == 21'h638 || bus_addr == 21'h400) |-> bus_rdata == 32'h0);

endmodule

bind fbctl_regfile fbctl_regfile_chk #(.DIM_W(DIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
  .irq(irq), .force_blank(force_blank), .cursor_on(cursor_on),
  .depth_bits(depth_bits), .cursor_x(cursor_x), .cursor_y(cursor_y),
  .screen_base(screen_base), .width_px(width_px), .height_ln(height_ln)
);

// File: tb/fbctl_regfile_test.sv
module fbctl_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_done = 1'b0;
  logic        irq;
  logic [7:0]  pix_index = '0;
  logic [23:0] pix_rgb;
  logic [1:0]  curs_idx = '0;
  logic [23:0] curs_rgb;
  logic [8:0]  pat_index = '0;
  logic [15:0] pat_word;
  logic        force_blank, cursor_on;
  logic [4:0]  depth_bits;
  logic [19:0] cursor_x;
  logic [11:0] cursor_y;
  logic [31:0] screen_base;
  logic [15:0] width_px, height_ln;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fbctl_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
    .irq(irq), .pix_index(pix_index), .pix_rgb(pix_rgb), .curs_idx(curs_idx),
    .curs_rgb(curs_rgb), .pat_index(pat_index), .pat_word(pat_word),
    .force_blank(force_blank), .cursor_on(cursor_on), .depth_bits(depth_bits),
    .cursor_x(cursor_x), .cursor_y(cursor_y), .screen_base(screen_base),
    .width_px(width_px), .height_ln(height_ln)
  );

  typedef struct packed {
    logic        wr;
    logic [20:0] addr;
    logic [31:0] data;  // write data, or expected read data
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 21'h118, 32'h0000_0140},  // R4
    '{1'b0, 21'h118, 32'h0000_0140},
    '{1'b1, 21'h150, 32'h0000_03C1},  // R5 odd value rounds down
    '{1'b0, 21'h150, 32'h0000_03C0},
    '{1'b1, 21'h300, 32'h00A0_0400},  // R6
    '{1'b0, 21'h300, 32'h00A0_0400},
    '{1'b1, 21'h508, 32'h0012_3456},  // R2
    '{1'b1, 21'h518, 32'hFFAB_CDEF},
    '{1'b0, 21'h508, 32'h0012_3456},
    '{1'b0, 21'h518, 32'h00AB_CDEF},
    '{1'b0, 21'h510, 32'h0000_0000},
    '{1'b1, 21'h1008, 32'hFFFF_5A5A}, // R3
    '{1'b0, 21'h1008, 32'h0000_5A5A},
    '{1'b0, 21'h1000, 32'h0000_0000},
    '{1'b1, 21'h808, 32'h0011_2233},  // R1
    '{1'b0, 21'h808, 32'h0000_0000},
    '{1'b1, 21'h000, 32'hDEAD_BEEF},  // R9
    '{1'b1, 21'h108, 32'h0000_1234},
    '{1'b1, 21'h200, 32'h0000_5555},
    '{1'b1, 21'h170, 32'hFFFF_FFFF},
    '{1'b0, 21'h000, 32'h0000_0000},
    '{1'b0, 21'h300, 32'h00A0_0400},
    '{1'b0, 21'h150, 32'h0000_03C0},
    '{1'b0, 21'h004, 32'h0000_0000},
    '{1'b0, 21'h638, 32'h0000_0000},
    '{1'b1, 21'h118, 32'h0000_4001},  // R4 truncation to 16 bits
    '{1'b0, 21'h118, 32'h0000_0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 21'h004; bus_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [20:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 irq", 32'(irq), 0);
    check("R12 width", 32'(width_px), 0);
    check("R12 cursor_on", 32'(cursor_on), 1);
    check("R12 depth", 32'(depth_bits), 1);
    check("R12 blank", 32'(force_blank), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else rd($sformatf("vector %0d", i), VEC[i].addr, VEC[i].data);
    end

    // R1 lookup through the pixel port, including top entry
    wr(21'hFF8, 32'hFFC0_FFEE);
    pix_index = 8'd1;   #1 check("R1 pix 1", 32'(pix_rgb), 32'h112233);
    pix_index = 8'd255; #1 check("R1 pix 255", 32'(pix_rgb), 32'hC0FFEE);
    // R2 cursor colours via pixel port
    curs_idx = 2'd2; #1 check("R2 curs 2", 32'(curs_rgb), 32'hABCDEF);
    curs_idx = 2'd3; #1 check("R2 curs 3", 32'(curs_rgb), 32'h0);
    // R3 bitmap
    pat_index = 9'd1; #1 check("R3 pat 1", 32'(pat_word), 32'h5A5A);
    // R6 flags from 0x00A00400
    check("R6 blank", 32'(force_blank), 1);
    check("R6 cursor_on", 32'(cursor_on), 0);
    check("R5 height", 32'(height_ln), 32'h1E0);
    check("R4 width", 32'(width_px), 32'h4);

    // R7 depth table
    for (int c = 0; c < 8; c++) begin
      logic [4:0] e;
      e = (c == 0) ? 5'd1 : (c == 1) ? 5'd2 : (c == 2) ? 5'd4 : (c == 3) ? 5'd8 :
          (c == 4) ? 5'd15 : (c == 5) ? 5'd16 : 5'd0;
      wr(21'h300, 32'(c) << 20);
      check($sformatf("R7 code %0d", c), 32'(depth_bits), 32'(e));
    end
    check("R6 cursor_on after clear", 32'(cursor_on), 1);

    // R8 cursor position and screen base
    wr(21'h638, 32'h0012_3456);
    check("R8 cursor_x", 32'(cursor_x), 32'h123);
    check("R8 cursor_y", 32'(cursor_y), 32'h456);
    wr(21'h400, 32'h0020_0000);
    check("R8 base", screen_base, 32'h0020_0000);

    // R11 interrupt behaviour
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    check("R11 set", 32'(irq), 1);
    repeat (2) @(negedge clk);
    check("R11 hold", 32'(irq), 1);
    @(negedge clk); frame_done = 1'b1; bus_we = 1'b1; bus_addr = 21'h004;
    @(negedge clk); frame_done = 1'b0; bus_we = 1'b0;
    check("R11 clear wins", 32'(irq), 0);
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    check("R11 set again", 32'(irq), 1);

    // R10 soft reset
    wr(21'h300, 32'h0080_0400);
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    wr(21'h100000, 32'h0);
    check("R10 irq", 32'(irq), 0);
    check("R10 cursor_x", 32'(cursor_x), 0);
    check("R10 base", screen_base, 0);
    check("R10 blank", 32'(force_blank), 0);
    check("R10 height", 32'(height_ln), 0);
    pix_index = 8'd255; #1 check("R10 lookup", 32'(pix_rgb), 0);
    curs_idx = 2'd2;    #1 check("R10 curs", 32'(curs_rgb), 0);
    pat_index = 9'd1;   #1 check("R10 pat", 32'(pat_word), 0);
    rd("R10 width read", 21'h118, 32'h0);
    rd("R10 ctrl read", 21'h300, 32'h0);

    summary();
  end

endmodule